// File: doc/BRIEF.md
# Load/Store Unit with Width Extension and Alignment Checking

This block sits between a processor's execute stage and a 32-bit data memory port. Each request carries an operation code, a base register value, a signed 16-bit displacement and, for writes, the value to store. The block adds the base and the sign-extended displacement to form the byte address. It then drives a word-aligned memory request with per-byte lane enables and lane-placed write data.

The unit supports three access sizes: byte, halfword and word. Reads of a byte or a halfword can be widened to 32 bits with either zero fill or sign fill. The data layout in memory is big-endian, so the lowest byte address of a word occupies its most significant lane.

Before an access goes out, its address is checked against the natural alignment of its size. A misaligned halfword or word access never reaches memory and is reported on a fault output instead. The memory is synchronous with one cycle of read latency, so a read result appears one cycle after its request.

Top module: `lsu_core`

## Requirements
- R1: The effective address is baseVal plus offsetVal sign-extended from bit 15, modulo 2^32; memAddr carries that address with its two low bits cleared.
- R2: opCode encodes the operation: 0 byte read zero-filled, 1 byte read sign-filled, 2 halfword read zero-filled, 3 halfword read sign-filled, 4 word read, 5 byte write, 6 halfword write, 7 word write; memWe is high exactly for codes 5 to 7.
- R3: Placement is big-endian. The byte at address offset k within a word (k = address bits 1:0) uses data bits [31-8k:24-8k] and enable bit memBe[3-k]. A halfword uses two adjacent lanes, with its lower-addressed byte in the more significant lane.
- R4: A byte read returns the addressed byte in bits 7:0, with bits 31:8 zero for code 0 and copies of byte bit 7 for code 1.
- R5: A halfword read returns the halfword in bits 15:0, with bits 31:16 zero for code 2 and copies of halfword bit 15 for code 3. A word read returns the whole addressed word.
- R6: Byte accesses never fault. A halfword access faults when address bit 0 is set, and a word access faults when address bits 1:0 are nonzero. Writes obey the same rules as reads. alignFault is high in the cycle after a faulting request.
- R7: A faulting request leaves memReq low and memBe zero, so memory contents stay unchanged. It produces no resultValid.
- R8: A write enables exactly the lanes it covers (one, two or four). memWdata holds the store value's low byte, low halfword or whole word in those lanes and zero in every other lane.
- R9: An accepted read raises resultValid for exactly one cycle, the cycle after its request, with the result on resultData. Writes never raise resultValid.
- R10: In reset and with no request, memReq, resultValid and alignFault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is presented this cycle |
| opCode | input | 3 | Operation code (see R2) |
| baseVal | input | 32 | Base register value |
| offsetVal | input | 16 | Signed displacement |
| storeData | input | 32 | Value to write, right-aligned |
| memReq | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 32 | Word-aligned memory address |
| memBe | output | 4 | Lane enables, bit 3 = bits 31:24 |
| memWdata | output | 32 | Lane-placed write data |
| memRdata | input | 32 | Read word, valid the cycle after a read request |
| resultValid | output | 1 | Read result valid |
| resultData | output | 32 | Extended read result |
| alignFault | output | 1 | Previous cycle's request was misaligned |

## Verification
The assertions assume that memRdata holds the addressed word in the cycle after every read request, and that reqValid stays low while reset is applied. The bench meets both by providing a one-cycle synchronous memory driven only from the block's own memReq, memWe, memBe and memWdata. It holds every request input at zero until reset is released. It issues at most one request per cycle and keeps addresses inside the modelled 64 bytes, so a read-back after a write or a blocked write always refers to bytes the bench is tracking.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [2:0] {
    OP_RD_BYTE_U = 3'd0,
    OP_RD_BYTE_S = 3'd1,
    OP_RD_HALF_U = 3'd2,
    OP_RD_HALF_S = 3'd3,
    OP_RD_WORD   = 3'd4,
    OP_WR_BYTE   = 3'd5,
    OP_WR_HALF   = 3'd6,
    OP_WR_WORD   = 3'd7
  } lsuOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic     issue;    // drive a memory access this cycle
    logic     write;    // access is a write
    logic     capture;  // latch read-return context
    logic     signExt;  // read result is sign-filled
    accSize_e size;
  } lsuStrobe_t;

endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [2:0]        opCode,
  input  logic [LANE_W-1:0] eaLow,
  output lsuStrobe_t        strobe,
  output logic              resultValid,
  output logic              alignFault
);

  lsuOp_e   opDec;
  accSize_e sizeDec;
  logic     isWrite;
  logic     isSigned;
  logic     misaligned;

  always_comb begin
    opDec    = lsuOp_e'(opCode);
    sizeDec  = SZ_BYTE;
    isWrite  = 1'b0;
    isSigned = 1'b0;
    unique case (opDec)
      OP_RD_BYTE_U: sizeDec = SZ_BYTE;
      OP_RD_BYTE_S: begin sizeDec = SZ_BYTE; isSigned = 1'b1; end
      OP_RD_HALF_U: sizeDec = SZ_HALF;
      OP_RD_HALF_S: begin sizeDec = SZ_HALF; isSigned = 1'b1; end
      OP_RD_WORD:   sizeDec = SZ_WORD;
      OP_WR_BYTE:   begin sizeDec = SZ_BYTE; isWrite = 1'b1; end
      OP_WR_HALF:   begin sizeDec = SZ_HALF; isWrite = 1'b1; end
      OP_WR_WORD:   begin sizeDec = SZ_WORD; isWrite = 1'b1; end
    endcase
  end

  // natural alignment per access size
  always_comb begin
    unique case (sizeDec)
      SZ_HALF: misaligned = eaLow[0];
      SZ_WORD: misaligned = |eaLow;
      default: misaligned = 1'b0;
    endcase
  end

  always_comb begin
    strobe.issue   = reqValid & ~misaligned;
    strobe.write   = isWrite;
    strobe.capture = reqValid & ~misaligned & ~isWrite;
    strobe.signExt = isSigned;
    strobe.size    = sizeDec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultValid <= 1'b0;
      alignFault  <= 1'b0;
    end else begin
      resultValid <= strobe.capture;
      alignFault  <= reqValid & misaligned;
    end
  end

endmodule

// File: rtl/lsu_dpath.sv
module lsu_dpath
  import lsu_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DATA_W = 32,
  parameter  int OFF_W  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lsuStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [OFF_W-1:0]  offsetVal,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [LANE_W-1:0] eaLow,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memBe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] resultData
);

  logic [ADDR_W-1:0] effAddr;
  logic [LANE_W:0]   accBytes;

  assign effAddr = baseVal + {{(ADDR_W-OFF_W){offsetVal[OFF_W-1]}}, offsetVal};
  assign eaLow   = effAddr[LANE_W-1:0];
  assign memAddr = {effAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign memReq  = strobe.issue;
  assign memWe   = strobe.issue & strobe.write;

  always_comb begin
    unique case (strobe.size)
      SZ_HALF: accBytes = (LANE_W+1)'(2);
      SZ_WORD: accBytes = (LANE_W+1)'(LANES);
      default: accBytes = (LANE_W+1)'(1);
    endcase
  end

  // lane g holds the byte at word offset LANES-1-g (big-endian)
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LANE_W-1:0] BYTE_POS = LANE_W'(LANES - 1 - g);
    logic [LANE_W-1:0] relPos;
    logic [LANE_W-1:0] srcSel;
    logic              inAccess;
    logic [7:0]        laneByte;

    always_comb begin
      relPos   = BYTE_POS - eaLow;
      inAccess = {1'b0, relPos} < accBytes;
      srcSel   = LANE_W'(accBytes - 1'b1) - relPos;
      laneByte = (strobe.issue & strobe.write & inAccess) ? storeData[8*srcSel +: 8] : 8'h00;
    end

    assign memBe[g]          = strobe.issue & inAccess;
    assign memWdata[8*g +: 8] = laneByte;
  end

  // read-return context
  logic [LANE_W-1:0] lowQ;
  accSize_e          sizeQ;
  logic              signQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowQ  <= '0;
      sizeQ <= SZ_BYTE;
      signQ <= 1'b0;
    end else if (strobe.capture) begin
      lowQ  <= eaLow;
      sizeQ <= strobe.size;
      signQ <= strobe.signExt;
    end
  end

  logic [LANE_W-1:0] byteSel;
  logic [LANE_W-1:0] halfSel;
  logic [7:0]        byteVal;
  logic [15:0]       halfVal;

  always_comb begin
    byteSel = LANE_W'(LANES - 1) - lowQ;
    halfSel = LANE_W'(LANES - 2) - lowQ;
    halfSel[0] = 1'b0;
    byteVal = memRdata[8*byteSel +: 8];
    halfVal = memRdata[8*halfSel +: 16];
    unique case (sizeQ)
      SZ_HALF: resultData = {{(DATA_W-16){signQ & halfVal[15]}}, halfVal};
      SZ_WORD: resultData = memRdata;
      default: resultData = {{(DATA_W-8){signQ & byteVal[7]}}, byteVal};
    endcase
  end

endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DATA_W = 32,
  parameter  int OFF_W  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [OFF_W-1:0]  offsetVal,
  input  logic [DATA_W-1:0] storeData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memBe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              alignFault
);

  lsuStrobe_t        strobe;
  logic [LANE_W-1:0] eaLow;

  lsu_ctrl #(
    .LANE_W(LANE_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .opCode     (opCode),
    .eaLow      (eaLow),
    .strobe     (strobe),
    .resultValid(resultValid),
    .alignFault (alignFault)
  );

  lsu_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFF_W (OFF_W)
  ) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .baseVal   (baseVal),
    .offsetVal (offsetVal),
    .storeData (storeData),
    .memRdata  (memRdata),
    .eaLow     (eaLow),
    .memReq    (memReq),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memBe     (memBe),
    .memWdata  (memWdata),
    .resultData(resultData)
  );

endmodule

// File: rtl/lsu_core_chk.sv
module lsu_core_chk #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              memReq,
  input logic              memWe,
  input logic [LANES-1:0]  memBe,
  input logic [DATA_W-1:0] memWdata,
  input logic              resultValid,
  input logic              alignFault
);

  logic [DATA_W-1:0] laneMask;
  always_comb begin
    for (int l = 0; l < LANES; l++) laneMask[8*l +: 8] = {8{memBe[l]}};
  end

  AST_FAULT_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    alignFault |-> !$past(memReq)); // R7

  AST_FAULT_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(alignFault && resultValid)); // R7

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |-> (!memReq && memBe == '0)); // R10

  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> ($countones(memBe) == 1 || $countones(memBe) == 2 || $countones(memBe) == LANES)); // R8

  AST_HALF_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && $countones(memBe) == 2) |-> (memBe == 4'b1100 || memBe == 4'b0011)); // R3

  AST_WRITE_IN_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe) |-> ((memWdata & ~laneMask) == '0)); // R8

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memWe) |=> resultValid); // R9

  AST_RESULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> $past(memReq && !memWe)); // R9

endmodule

bind lsu_core lsu_core_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/lsu_core_tb_top.sv
module lsu_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [31:0] baseVal = '0;
  logic [15:0] offsetVal = '0;
  logic [31:0] storeData = '0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata, resultData;
  logic [3:0]  memBe;
  logic [31:0] memRdata = '0;
  logic        resultValid, alignFault;

  always #10 clk = ~clk;  // 50 MHz

  lsu_core dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .opCode(opCode),
    .baseVal(baseVal), .offsetVal(offsetVal), .storeData(storeData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata), .resultValid(resultValid),
    .resultData(resultData), .alignFault(alignFault)
  );

  // synchronous memory seen by the block, big-endian bytes
  logic [7:0] modelMem [0:63];
  // bench's own expectation of memory
  logic [7:0] refMem [0:63];

  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) begin
        for (int l = 0; l < 4; l++)
          if (memBe[l]) modelMem[{memAddr[5:2], 2'(3 - l)}] <= memWdata[8*l +: 8];
      end else begin
        memRdata <= {modelMem[{memAddr[5:2], 2'd0}], modelMem[{memAddr[5:2], 2'd1}],
                     modelMem[{memAddr[5:2], 2'd2}], modelMem[{memAddr[5:2], 2'd3}]};
      end
    end
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  typedef struct {
    bit          expValid;
    bit          expFault;
    logic [31:0] expData;
    string       tag;
  } sbItem_t;

  sbItem_t sbQ[$];

  function automatic int sizeBytes(input logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd5: return 1;
      3'd2, 3'd3, 3'd6: return 2;
      default:          return 4;
    endcase
  endfunction

  function automatic logic [31:0] readExpect(input logic [2:0] op, input logic [31:0] ea);
    logic [7:0]  b;
    logic [15:0] h;
    logic [31:0] w;
    b = refMem[ea[5:0]];
    h = {refMem[ea[5:0]], refMem[ea[5:0] + 6'd1]};
    w = {refMem[ea[5:0]], refMem[ea[5:0] + 6'd1], refMem[ea[5:0] + 6'd2], refMem[ea[5:0] + 6'd3]};
    case (op)
      3'd0:    return {24'h0, b};
      3'd1:    return {{24{b[7]}}, b};
      3'd2:    return {16'h0, h};
      3'd3:    return {{16{h[15]}}, h};
      default: return w;
    endcase
  endfunction

  // driver: presents one request and pushes its expected response
  task automatic doOp(input logic [2:0] op, input logic [31:0] base, input logic [15:0] off,
                      input logic [31:0] sd, input string tag);
    logic [31:0] ea, wdExp;
    logic [3:0]  beExp;
    int          nb;
    bit          bad, isWr;
    sbItem_t     it;
    @(negedge clk);
    reqValid = 1'b1; opCode = op; baseVal = base; offsetVal = off; storeData = sd;
    ea   = base + {{16{off[15]}}, off};
    nb   = sizeBytes(op);
    isWr = (op >= 3'd5);
    bad  = (nb == 2 && ea[0]) || (nb == 4 && ea[1:0] != 2'd0);
    it.expValid = !bad && !isWr;
    it.expFault = bad;
    it.expData  = readExpect(op, ea);
    it.tag      = tag;
    #1;
    chk(memReq === !bad, {tag, " R6 request issued only when aligned"}, 32'(memReq), 32'(!bad));
    if (!bad) begin
      beExp = (nb == 1) ? (4'b1000 >> ea[1:0]) : (nb == 2) ? (4'b1100 >> ea[1:0]) : 4'b1111;
      wdExp = (nb == 1) ? ({24'h0, sd[7:0]} << (8 * (3 - ea[1:0]))) :
              (nb == 2) ? ({16'h0, sd[15:0]} << (8 * (2 - ea[1:0]))) : sd;
      chk(memAddr === {ea[31:2], 2'b00}, {tag, " R1 address"}, memAddr, {ea[31:2], 2'b00});
      chk(memBe === beExp, {tag, " R3 lane enables"}, 32'(memBe), 32'(beExp));
      chk(memWe === isWr, {tag, " R2 write decode"}, 32'(memWe), 32'(isWr));
      if (isWr) begin
        chk(memWdata === wdExp, {tag, " R8 write data placement"}, memWdata, wdExp);
        for (int i = 0; i < nb; i++) refMem[ea[5:0] + 6'(i)] = sd[8*(nb-1-i) +: 8];
      end
    end else begin
      chk(memBe === 4'b0 && memWe === 1'b0, {tag, " R7 blocked access has no lanes"},
          {memWe, 27'h0, memBe}, 32'h0);
    end
    sbQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0; opCode = '0; baseVal = '0; offsetVal = '0; storeData = '0;
    end
  endtask

  // monitor: compares outputs against the scoreboard one cycle after each request
  initial begin
    sbItem_t it;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      #2;
      if (sbQ.size() > 0) begin
        it = sbQ.pop_front();
        chk(resultValid === it.expValid, {it.tag, " R9 result valid"}, 32'(resultValid), 32'(it.expValid));
        chk(alignFault === it.expFault, {it.tag, " R6 fault flag"}, 32'(alignFault), 32'(it.expFault));
        if (it.expValid)
          chk(resultData === it.expData, {it.tag, " R4/R5 read data"}, resultData, it.expData);
      end else begin
        chk(resultValid === 1'b0 && alignFault === 1'b0, "R10 quiet when idle",
            {30'h0, resultValid, alignFault}, 32'h0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", sbQ.size());
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      modelMem[i] = 8'((i * 53 + 145) % 256);
      refMem[i]   = 8'((i * 53 + 145) % 256);
    end
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    chk(memReq === 1'b0 && resultValid === 1'b0 && alignFault === 1'b0, "R10 reset outputs low",
        {29'h0, memReq, resultValid, alignFault}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1: negative offset, zero offset, wrap-around both ways
    doOp(3'd4, 32'h0000_0040, 16'hFFC4, '0, "R1 neg offset");
    doOp(3'd4, 32'h0000_0008, 16'h0000, '0, "R1 zero offset");
    doOp(3'd0, 32'hFFFF_FFF0, 16'h0014, '0, "R1 wrap");
    doOp(3'd0, 32'hFFFF_8010, 16'h7FFF, '0, "R1 max offset");
    idle(1);

    // R4: byte reads, each lane, both fills
    for (int k = 0; k < 4; k++) doOp(3'd0, 32'h0000_000C, 16'(k), '0, "R4 byte zero-fill");
    for (int k = 0; k < 4; k++) doOp(3'd1, 32'h0000_000C, 16'(k), '0, "R4 byte sign-fill");
    // R5: halfword and word reads
    doOp(3'd2, 32'h0000_0010, 16'h0000, '0, "R5 half zero-fill lo");
    doOp(3'd2, 32'h0000_0010, 16'h0002, '0, "R5 half zero-fill hi");
    doOp(3'd3, 32'h0000_0014, 16'h0000, '0, "R5 half sign-fill lo");
    doOp(3'd3, 32'h0000_0014, 16'h0002, '0, "R5 half sign-fill hi");
    doOp(3'd4, 32'h0000_0018, 16'h0000, '0, "R5 word");
    idle(2);

    // R8/R3: writes in every lane, then read back
    doOp(3'd5, 32'h0000_0020, 16'h0000, 32'hFFFF_FF81, "R8 byte write k0");
    doOp(3'd5, 32'h0000_0020, 16'h0001, 32'h0000_0042, "R8 byte write k1");
    doOp(3'd5, 32'h0000_0020, 16'h0002, 32'h1234_56C3, "R8 byte write k2");
    doOp(3'd5, 32'h0000_0020, 16'h0003, 32'h0000_0004, "R8 byte write k3");
    doOp(3'd4, 32'h0000_0020, 16'h0000, '0, "R3 byte order readback");
    doOp(3'd6, 32'h0000_0024, 16'h0000, 32'hAAAA_9ABC, "R8 half write lo");
    doOp(3'd6, 32'h0000_0024, 16'h0002, 32'h5555_1357, "R8 half write hi");
    doOp(3'd4, 32'h0000_0024, 16'h0000, '0, "R3 half order readback");
    doOp(3'd7, 32'h0000_0028, 16'h0000, 32'hDEAD_BEEF, "R8 word write");
    doOp(3'd3, 32'h0000_0028, 16'h0000, '0, "R5 signed half after word write");
    doOp(3'd1, 32'h0000_0028, 16'h0003, '0, "R4 signed byte after word write");
    doOp(3'd2, 32'h0000_002A, 16'h0000, '0, "R5 half after word write");
    idle(1);

    // R6/R7: misaligned accesses of each kind, then check memory untouched
    doOp(3'd2, 32'h0000_0011, 16'h0000, '0, "R6 half read odd");
    doOp(3'd4, 32'h0000_001E, 16'h0000, '0, "R6 word read offset2");
    doOp(3'd7, 32'h0000_0020, 16'h0001, 32'h0102_0304, "R7 word write offset1");
    doOp(3'd6, 32'h0000_0027, 16'h0000, 32'h0000_FFFF, "R7 half write odd");
    doOp(3'd3, 32'h0000_0005, 16'hFFFE, '0, "R6 signed half odd");
    doOp(3'd5, 32'h0000_002F, 16'h0000, 32'h0000_0077, "R6 byte write odd ok");
    doOp(3'd4, 32'h0000_0020, 16'h0000, '0, "R7 memory unchanged w0");
    doOp(3'd4, 32'h0000_0024, 16'h0000, '0, "R7 memory unchanged w1");
    doOp(3'd4, 32'h0000_002C, 16'h0000, '0, "R6 byte write landed");
    idle(3);

    wait (sbQ.size() == 0);
    idle(1);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule